// File: doc/BRIEF.md
# Two-Wire Bus Master with Internal-Address Phase

This block is a two-wire (I2C-style) bus master driven by a small set of host registers. When the host pulses `start`, the master generates a START condition and sends the 7-bit device address with a direction bit. It can then send zero to three internal-address bytes. After that it either writes data bytes taken from a transmit holding register or reads bytes into a receive holding register. The clock line and the data line are open-drain: the block only pulls a line low, through `scl_oe` and `sda_oe`.

For a read with a nonzero internal-address size, the master first writes the internal-address bytes. It then issues a repeated START and sends the device address again with the read bit. The host decides where a transfer ends through `stop_req`. On a write, an empty holding register with `stop_req` high ends the frame. With `stop_req` low the master parks the clock low and waits for the next byte. On a read, `stop_req` high at the acknowledge slot turns that acknowledge into a NACK, and a STOP follows.

The internal-address field also serves 10-bit devices. Set the size to one and put `11110` plus the two top address bits in the device address. The internal-address register then holds the lower eight bits.

Top module: `i2c_addr_master`

## Requirements
- R1: After reset, both open-drain enables are 0 (lines released), `txcomp`=1, `txrdy`=1, `rxrdy`=0 and `nack`=0.
- R2: A write transfer appears on the bus as START, the byte {dev_addr, 0}, the internal-address bytes, the data bytes in the order written, then STOP. Each byte goes out most significant bit first and is followed by an acknowledge clock. A low acknowledge means ACK.
- R3: With internal-address size N (0..3), exactly the lowest N bytes of `iadr` are sent, highest first: bits 23:16, then 15:8, then 7:0 (for N=3).
- R4: `txrdy` falls when `thr_wr` fills the holding register. It rises again when the byte is moved into the shifter, before that byte has appeared on the bus.
- R5: When a data byte is due and the holding register is empty, `stop_req` high produces STOP. With `stop_req` low, SCL is held low until `thr_wr` arrives, and the transfer then continues.
- R6: `txcomp` falls on `start` and rises only after the STOP condition has completed.
- R7: A read with size 0 sends START and {dev_addr, 1}, then receives bytes MSB first. Each received byte appears on `rhr_data` with `rxrdy` set.
- R8: A read with size N>0 first sends START, {dev_addr, 0} and the N internal-address bytes. It then sends a repeated START and {dev_addr, 1} before receiving.
- R9: The master drives ACK (low) after every received byte except one whose acknowledge slot begins while `stop_req` is high. That byte gets a NACK (released line), followed by STOP.
- R10: `rhr_rd` clears `rxrdy`, unless a new byte lands in the same cycle.
- R11: If the slave does not acknowledge an address or data byte, `nack` rises, STOP is generated and `txcomp` is set. `nack` clears on the next `start`.
- R12: SDA changes only while SCL is low, except at START and STOP, which occur only at byte boundaries.
- R13: A 10-bit device is reached with size 1, `dev_addr`=11110 followed by the top two address bits, and `iadr[7:0]` holding the lower eight bits.
- R14: Within a byte, consecutive SCL rising edges are 4*(`clk_div`+1) clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_div | input | DIV_W | Quarter-bit divider: each SCL quarter lasts clk_div+1 cycles |
| start | input | 1 | Pulse that begins a transfer when idle |
| stop_req | input | 1 | Ends a write on an empty holding register; marks the last read byte |
| dev_addr | input | 7 | Device address |
| rd_mode | input | 1 | 1 = read transfer, 0 = write transfer |
| iadr_size | input | 2 | Number of internal-address bytes, 0..3 |
| iadr | input | 24 | Internal address |
| thr_wr | input | 1 | Write strobe of the transmit holding register |
| thr_data | input | 8 | Byte written into the transmit holding register |
| txrdy | output | 1 | Transmit holding register empty |
| rhr_rd | input | 1 | Read strobe of the receive holding register |
| rhr_data | output | 8 | Last received byte |
| rxrdy | output | 1 | Receive holding register holds an unread byte |
| txcomp | output | 1 | No transfer in progress |
| nack | output | 1 | The slave failed to acknowledge a byte |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed level of SDA |

## Verification
The hardest path to reach is a read with a nonzero internal-address size that ends on a chosen byte. It needs a repeated START in the middle of the frame, a slave that switches from receiving to driving data, and a `stop_req` change placed between two acknowledge slots. The bench has a bus-level slave model that decodes START, STOP, bits and acknowledges from the open-drain lines. It answers reads from a queue of bytes. The driver raises `stop_req` only after the next-to-last byte has been read out. The stalled-write case is reached by withholding the second data byte with `stop_req` low and checking that the clock stays parked low.

// File: rtl/i2c_addr_master.sv
module i2c_addr_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             start,
  input  logic             stop_req,
  input  logic [6:0]       dev_addr,
  input  logic             rd_mode,
  input  logic [1:0]       iadr_size,
  input  logic [23:0]      iadr,
  input  logic             thr_wr,
  input  logic [7:0]       thr_data,
  output logic             txrdy,
  input  logic             rhr_rd,
  output logic [7:0]       rhr_data,
  output logic             rxrdy,
  output logic             txcomp,
  output logic             nack,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  localparam int ACK_SLOT = 8;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_HOLD, S_RSTART, S_STOP} st_t;

  st_t              st;
  logic [1:0]       q;
  logic [DIV_W-1:0] cnt;
  logic [7:0]       sh, thr;
  logic [3:0]       bitn;
  logic [1:0]       ia_left;
  logic             rx, rd_addr, is_dev, last_rx, ackr, thr_full;
  logic [6:0]       dev_r;
  logic             rw_r;
  logic [23:0]      iadr_r;

  wire tick    = (st != S_IDLE) && (cnt == clk_div);
  wire rx_load = tick && st == S_BIT && q == 2'd2 && rx && bitn == 4'd7;
  wire [7:0] ia_byte = (ia_left == 2'd3) ? iadr_r[23:16] :
                       (ia_left == 2'd2) ? iadr_r[15:8] : iadr_r[7:0];
  wire bitv = (bitn == ACK_SLOT[3:0]) ? (rx ? last_rx : 1'b1) : (rx ? 1'b1 : sh[7]);

  assign txrdy  = !thr_full;
  assign scl_oe = (st == S_HOLD) || (st == S_START && q == 2'd3) ||
                  ((st == S_BIT || st == S_RSTART) && (q == 2'd0 || q == 2'd3)) ||
                  (st == S_STOP && q == 2'd0);
  assign sda_oe = (st == S_START && q != 2'd0) || (st == S_RSTART && q[1]) ||
                  (st == S_STOP && !q[1]) || (st == S_BIT && !bitv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  q <= '0;  cnt <= '0;  sh <= '0;  thr <= '0;  bitn <= '0;
      ia_left <= '0; rx <= 1'b0; rd_addr <= 1'b0; is_dev <= 1'b0; last_rx <= 1'b0;
      ackr <= 1'b0;  thr_full <= 1'b0; dev_r <= '0; rw_r <= 1'b0; iadr_r <= '0;
      rhr_data <= '0; rxrdy <= 1'b0; txcomp <= 1'b1; nack <= 1'b0;
    end else begin
      cnt <= (st == S_IDLE || tick) ? '0 : cnt + 1'b1;
      if (tick) q <= q + 2'd1;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_START;
          q       <= '0;
          txcomp  <= 1'b0;
          nack    <= 1'b0;
          rx      <= 1'b0;
          dev_r   <= dev_addr;
          rw_r    <= rd_mode;
          iadr_r  <= iadr;
          ia_left <= iadr_size;
          rd_addr <= rd_mode && iadr_size == 2'd0;
        end
        S_START: if (tick && q == 2'd3) begin
          st <= S_BIT;  sh <= {dev_r, rd_addr};  bitn <= '0;  is_dev <= 1'b1;
        end
        S_RSTART: if (tick && q == 2'd3) begin
          st <= S_BIT;  sh <= {dev_r, 1'b1};  bitn <= '0;  is_dev <= 1'b1;  rd_addr <= 1'b1;
        end
        S_STOP: if (tick && q == 2'd3) begin
          st <= S_IDLE;  txcomp <= 1'b1;
        end
        S_HOLD: if (tick) begin
          q <= '0;
          if (thr_full) begin
            st <= S_BIT;  sh <= thr;  thr_full <= 1'b0;  bitn <= '0;  is_dev <= 1'b0;
          end else if (stop_req) begin
            st <= S_STOP;
          end
        end
        S_BIT: if (tick) begin
          if (q == 2'd2) begin
            if (bitn == ACK_SLOT[3:0]) ackr <= sda_in;
            else if (rx) sh <= {sh[6:0], sda_in};
          end
          if (q == 2'd3) begin
            if (bitn != ACK_SLOT[3:0]) begin
              bitn <= bitn + 4'd1;
              if (!rx) sh <= {sh[6:0], 1'b0};
              if (rx && bitn == 4'd7) last_rx <= stop_req;
            end else begin
              bitn <= '0;
              if (!rx && ackr) begin
                nack <= 1'b1;
                st   <= S_STOP;
              end else if (rx) begin
                if (last_rx) st <= S_STOP;
              end else if (is_dev && rd_addr) begin
                rx <= 1'b1;  is_dev <= 1'b0;
              end else if (ia_left != 2'd0) begin
                sh <= ia_byte;  ia_left <= ia_left - 2'd1;  is_dev <= 1'b0;
              end else if (rw_r) begin
                st <= S_RSTART;
              end else begin
                st <= S_HOLD;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
      if (thr_wr) begin
        thr      <= thr_data;
        thr_full <= 1'b1;
      end
      if (rx_load) begin
        rhr_data <= {sh[6:0], sda_in};
        rxrdy    <= 1'b1;
      end else if (rhr_rd) begin
        rxrdy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_addr_master_chk.sv
module i2c_addr_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       txcomp,
  input logic       nack,
  input logic       rxrdy,
  input logic       rhr_rd,
  input logic       rx_load,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [2:0] st
);
  localparam logic [2:0] ST_BIT  = 3'd2;
  localparam logic [2:0] ST_STOP = 3'd5;

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    txcomp |-> (!scl_oe && !sda_oe)); // R6

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && txcomp) |=> !txcomp); // R6

  AST_READ_CLEARS_RXRDY: assert property (@(posedge clk) disable iff (!rst_n)
    (rhr_rd && !rx_load) |=> !rxrdy); // R10

  AST_NACK_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack) |-> (st == ST_STOP)); // R11

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && $past(st) == ST_BIT && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R12
endmodule

bind i2c_addr_master i2c_addr_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .txcomp(txcomp), .nack(nack),
  .rxrdy(rxrdy), .rhr_rd(rhr_rd), .rx_load(rx_load), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .st(st)
);

// File: tb/tb_i2c_addr_master.sv
module tb_i2c_addr_master;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, stop_req, rd_mode, thr_wr, rhr_rd, slv_low;
  logic [7:0] clk_div, thr_data;
  logic [6:0] dev_addr;
  logic [1:0] iadr_size;
  logic [23:0] iadr;
  logic txrdy, rxrdy, txcomp, nack, scl_oe, sda_oe;
  logic [7:0] rhr_data;
  wire sda_line = !sda_oe && !slv_low;
  wire scl_line = !scl_oe;

  i2c_addr_master dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .start(start), .stop_req(stop_req),
    .dev_addr(dev_addr), .rd_mode(rd_mode), .iadr_size(iadr_size), .iadr(iadr),
    .thr_wr(thr_wr), .thr_data(thr_data), .txrdy(txrdy), .rhr_rd(rhr_rd),
    .rhr_data(rhr_data), .rxrdy(rxrdy), .txcomp(txcomp), .nack(nack),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  logic [7:0] rd_q[$];
  logic [7:0] wq[$];
  int nack_at = -1, exp_period = 12, nbyte = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic got(input int code, input string tag);
    if (exp_q.size() == 0) chk(1'b0, tag, code, -1);
    else begin
      int e;
      e = exp_q.pop_front();
      chk(e == code, tag, code, e);
    end
  endtask

  // Scoreboard monitor: bus-level slave that decodes the lines and answers
  bit pscl = 1, psda = 1, s_scl, s_sda, ackph, stx, go_tx, mack, first;
  int bitcnt = 0;
  logic [7:0] sb, tb_byte;
  longint cyc = 0, t_first = 0;
  always @(negedge clk) begin
    cyc++;
    s_scl = scl_line;
    s_sda = sda_line;
    if (!rst_n) begin
      slv_low = 1'b0; bitcnt = 0; ackph = 0; stx = 0; go_tx = 0; first = 0; mack = 0;
    end else if (pscl && s_scl && psda && !s_sda) begin
      chk(bitcnt <= 1 && !ackph, "R12 START at byte boundary", bitcnt, 0);
      got('h100, "R2 START");
      bitcnt = 0; ackph = 0; stx = 0; go_tx = 0; first = 1; slv_low = 1'b0;
    end else if (pscl && s_scl && !psda && s_sda) begin
      chk(bitcnt <= 1 && !ackph, "R12 STOP at byte boundary", bitcnt, 0);
      got('h101, "R2 STOP");
      bitcnt = 0; first = 0; stx = 0;
    end else if (!pscl && s_scl) begin
      if (!ackph) begin
        if (!stx) sb = {sb[6:0], s_sda};
        bitcnt++;
        if (bitcnt == 1) t_first = cyc;
        if (bitcnt == 8) chk(cyc - t_first == 7 * exp_period, "R14 SCL period",
                             int'(cyc - t_first), 7 * exp_period);
      end else if (stx) begin
        mack = s_sda;
        got('h200 | int'(s_sda), "R9 master acknowledge");
      end
    end else if (pscl && !s_scl) begin
      if (!ackph && bitcnt == 8) begin
        ackph = 1;
        if (!stx) begin
          got(int'(sb), "R2 byte on bus");
          slv_low = (nbyte != nack_at);
          if (first && sb[0]) go_tx = 1;
          first = 0;
          nbyte++;
        end else slv_low = 1'b0;
      end else if (ackph) begin
        ackph = 0; bitcnt = 0; slv_low = 1'b0;
        if (go_tx) begin stx = 1; go_tx = 0; mack = 0; end
        if (stx && !mack) begin
          tb_byte = (rd_q.size() > 0) ? rd_q.pop_front() : 8'hFF;
          slv_low = !tb_byte[7];
        end
      end else if (stx && bitcnt >= 1 && bitcnt < 8) begin
        slv_low = !tb_byte[7 - bitcnt];
      end
    end
    pscl = s_scl;
    psda = s_sda;
  end

  task automatic wait_flag(input int which, input string tag);
    int t = 0;
    while (t < 20000 && !((which == 0 && txcomp) || (which == 1 && (txrdy || txcomp)) ||
                          (which == 2 && rxrdy))) begin
      @(negedge clk); t++;
    end
    chk(t < 20000, tag, t, 0);
  endtask

  task automatic thr_put(input logic [7:0] v);
    @(negedge clk); thr_wr = 1'b1; thr_data = v;
    @(negedge clk); thr_wr = 1'b0;
    chk(txrdy == 1'b0, "R4 txrdy low when filled", txrdy, 0);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(txcomp == 1'b0, "R6 txcomp cleared by start", txcomp, 0);
    chk(nack == 1'b0, "R11 nack cleared by start", nack, 0);
  endtask

  task automatic setup(input logic [6:0] dv, input logic rd, input logic [1:0] sz,
                       input logic [23:0] ia);
    dev_addr = dv; rd_mode = rd; iadr_size = sz; iadr = ia; nbyte = 0;
    exp_q.push_back('h100);
    exp_q.push_back({dv, (rd && sz == 0)});
    for (int k = sz; k > 0; k--) exp_q.push_back(int'(ia[8*k-1 -: 8]));
  endtask

  task automatic run_write(input logic [6:0] dv, input logic [1:0] sz, input logic [23:0] ia,
                           input int nk, input bit exp_nack, input string tag);
    nack_at = nk;
    setup(dv, 1'b0, sz, ia);
    if (nk < 0 || nk > sz) begin
      foreach (wq[k]) begin
        exp_q.push_back(int'(wq[k]));
        if (nk == 1 + sz + k) break;
      end
    end
    exp_q.push_back('h101);
    stop_req = 1'b1;
    if (wq.size() > 0) thr_put(wq[0]);
    pulse_start();
    for (int i = 1; i < wq.size(); i++) begin
      wait_flag(1, "R4 txrdy wait");
      if (txcomp) break;
      chk(exp_q.size() >= 2, "R4 txrdy before byte shifted", exp_q.size(), 2);
      thr_put(wq[i]);
    end
    wait_flag(0, "R6 txcomp after write");
    chk(exp_q.size() == 0, {tag, " frame complete"}, exp_q.size(), 0);
    chk(nack == exp_nack, "R11 nack flag", nack, exp_nack);
  endtask

  task automatic run_read(input logic [6:0] dv, input logic [1:0] sz, input logic [23:0] ia,
                          input string tag);
    int n;
    n = wq.size();
    nack_at = -1;
    setup(dv, 1'b1, sz, ia);
    if (sz != 0) begin
      exp_q.push_back('h100);
      exp_q.push_back({dv, 1'b1});
    end
    for (int k = 0; k < n; k++) begin
      exp_q.push_back((k == n - 1) ? 'h201 : 'h200);
      rd_q.push_back(wq[k]);
    end
    exp_q.push_back('h101);
    stop_req = (n == 1);
    pulse_start();
    for (int k = 0; k < n; k++) begin
      wait_flag(2, "R7 rxrdy wait");
      chk(rhr_data == wq[k], "R7 received byte", rhr_data, wq[k]);
      @(negedge clk); rhr_rd = 1'b1;
      @(negedge clk); rhr_rd = 1'b0;
      chk(rxrdy == 1'b0, "R10 rxrdy cleared by read", rxrdy, 0);
      if (k == n - 2) begin
        repeat (20) @(negedge clk);
        stop_req = 1'b1;
      end
    end
    wait_flag(0, "R6 txcomp after read");
    chk(exp_q.size() == 0, {tag, " frame complete"}, exp_q.size(), 0);
    chk(nack == 1'b0, "R9 no nack on read", nack, 0);
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; stop_req = 0; rd_mode = 0; thr_wr = 0; rhr_rd = 0;
    clk_div = 8'd2; thr_data = 0; dev_addr = 0; iadr_size = 0; iadr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(txcomp && txrdy && !rxrdy && !nack, "R1 status flags",
        {txcomp, txrdy, rxrdy, nack}, 4'b1100);

    wq = '{8'h11, 8'h22, 8'h33};
    run_write(7'h50, 2'd0, 24'h0, -1, 1'b0, "R2 write size0");
    wq = '{8'hC3};
    run_write(7'h2A, 2'd3, 24'hABCDEF, -1, 1'b0, "R3 write size3");
    wq = '{8'h5E, 8'h01};
    run_write(7'h13, 2'd2, 24'h123456, -1, 1'b0, "R3 write size2");
    wq = '{8'h77};
    run_write(7'b1111010, 2'd1, 24'h00005A, -1, 1'b0, "R13 ten-bit device");
    wq.delete();
    run_write(7'h44, 2'd0, 24'h0, -1, 1'b0, "R5 zero-data write");

    // R5: empty holding register with no stop request parks SCL low
    nack_at = -1;
    setup(7'h21, 1'b0, 2'd0, 24'h0);
    exp_q.push_back('h3C); exp_q.push_back('h99); exp_q.push_back('h101);
    stop_req = 1'b0;
    thr_put(8'h3C);
    pulse_start();
    wait_flag(1, "R5 first byte loaded");
    repeat (400) @(negedge clk);
    chk(scl_oe == 1'b1, "R5 SCL held low", scl_oe, 1);
    chk(txcomp == 1'b0, "R5 transfer still open", txcomp, 0);
    chk(exp_q.size() == 2, "R5 no bus activity while held", exp_q.size(), 2);
    thr_put(8'h99);
    stop_req = 1'b1;
    wait_flag(0, "R6 txcomp after held write");
    chk(exp_q.size() == 0, "R5 held write frame complete", exp_q.size(), 0);

    wq = '{8'hA5, 8'h3C, 8'h96};
    run_read(7'h3B, 2'd0, 24'h0, "R7 read size0");
    clk_div = 8'd4; exp_period = 20;
    wq = '{8'h81, 8'h7E};
    run_read(7'h60, 2'd2, 24'h007788, "R8 read with internal address");
    wq = '{8'h0F};
    run_read(7'h09, 2'd1, 24'h0000C4, "R9 single byte read");
    clk_div = 8'd2; exp_period = 12;

    wq = '{8'h55, 8'h66};
    run_write(7'h31, 2'd0, 24'h0, 1, 1'b1, "R11 data NACK");
    wq.delete();
    run_write(7'h32, 2'd0, 24'h0, 0, 1'b1, "R11 address NACK");
    chk(txcomp == 1'b1 && !scl_oe && !sda_oe, "R11 bus released after NACK",
        {txcomp, scl_oe, sda_oe}, 3'b100);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule